// File: doc/BRIEF.md
# Display Timing Generator with Clock Select

This block derives every timing reference of a multiplexed character display from one oscillator clock. Each oscillator cycle is presented to the block as a one-cycle tick on a fast system clock. From those ticks it produces a row scan index with a frame pulse, a flash phase that blinks selected characters at a 50% duty cycle, and a busy flag that covers a fixed self-test window.

The tick source is chosen by a select input. With select high, the internal oscillator tick drives the counters and is also mirrored onto a shared clock pin whose output enable is raised, so slave displays can follow it. With select low, the pin is an input and its tick drives the counters. With default parameters a frame lasts 224 ticks (7 rows of 32) and a flash period lasts 28,672 ticks (128 frames). A self-test lasts 262,144 ticks. At a 57 kHz oscillator this gives roughly 256 Hz refresh and 2 Hz flash.

Top module: `disp_timing_gen`

## Requirements
- R1: While rst_ni is low, row_o is 0, frame_o is 0, flash_o is 0 and st_busy_o is 0.
- R2: When clk_sel_i is 1 only osc_tick_i advances the counters; when clk_sel_i is 0 only pin_tick_i does, and the unselected tick has no effect.
- R3: clk_pin_oe_o equals clk_sel_i, and clk_pin_o equals osc_tick_i when clk_sel_i is 1 and is 0 otherwise.
- R4: row_o advances by one after every ROW_CYC selected ticks and wraps from ROWS-1 to 0, so after n ticks it reads (n / ROW_CYC) mod ROWS.
- R5: frame_o is high, combinationally and for one clock, exactly in the cycle that presents the last selected tick of a frame, that is tick number k*ROW_CYC*ROWS counting from 1.
- R6: flash_o starts at 0 and inverts after every FLASH_FRAMES/2 frames, so after n ticks it reads (n / (ROW_CYC*ROWS*FLASH_FRAMES/2)) mod 2.
- R7: A st_start_i pulse while idle raises st_busy_o on the next clock. It stays high until ST_CYC selected ticks have occurred after the start cycle and drops on the clock that takes the last of them.
- R8: st_start_i while st_busy_o is high is ignored and does not move the end of the running window.
- R9: In a clock without a selected tick, row_o, flash_o and the self-test count hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock at which ticks are sampled |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clk_sel_i | input | 1 | 1 selects internal oscillator, 0 selects clock pin |
| osc_tick_i | input | 1 | One-cycle tick per internal oscillator cycle |
| pin_tick_i | input | 1 | One-cycle tick per cycle seen on the clock pin |
| clk_pin_o | output | 1 | Oscillator tick driven onto the shared clock pin |
| clk_pin_oe_o | output | 1 | Output enable of the shared clock pin |
| st_start_i | input | 1 | Self-test start pulse |
| row_o | output | $clog2(ROWS) | Current scan row index |
| frame_o | output | 1 | End-of-frame pulse |
| flash_o | output | 1 | Character flash phase |
| st_busy_o | output | 1 | Self-test window active |

## Verification
The bench builds the block with ROW_CYC=4, ROWS=7, FLASH_FRAMES=4 and ST_CYC=100. With these values a frame takes 28 ticks and a flash phase 56, so several row wraps, frame pulses and flash inversions fit into a few hundred cycles. The complete self-test window, including restart attempts during busy and a start that shares its cycle with a tick, also fits, next to source switching with ticks on the unselected input.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  typedef enum logic {
    SRC_PIN = 1'b0,
    SRC_OSC = 1'b1
  } tick_src_e;

  function automatic int unsigned cw(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/dtg_row_scan.sv
module dtg_row_scan #(
  parameter int unsigned ROW_CYC = 32,
  parameter int unsigned ROWS    = 7
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     tick_i,
  output logic [$clog2(ROWS)-1:0]  row_o,
  output logic                     frame_o
);
  localparam int unsigned CW = dtg_pkg::cw(ROW_CYC);
  localparam int unsigned RW = $clog2(ROWS);

  logic [CW-1:0] cyc_q;
  logic [RW-1:0] row_q;
  logic          last_cyc, last_row;

  assign last_cyc = (cyc_q == CW'(ROW_CYC - 1));
  assign last_row = (row_q == RW'(ROWS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
      row_q <= '0;
    end else if (tick_i) begin
      if (last_cyc) begin
        cyc_q <= '0;
        row_q <= last_row ? '0 : row_q + 1'b1;
      end else begin
        cyc_q <= cyc_q + 1'b1;
      end
    end
  end

  assign row_o   = row_q;
  assign frame_o = tick_i & last_cyc & last_row;

  p_row_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_o < RW'(ROWS));
  p_frame_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |=> (row_o == '0));
  p_row_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(row_o));
endmodule

// File: rtl/dtg_flash.sv
module dtg_flash #(
  parameter int unsigned FLASH_FRAMES = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_i,
  output logic flash_o
);
  localparam int unsigned HALF = FLASH_FRAMES / 2;
  localparam int unsigned HW   = dtg_pkg::cw(HALF);

  logic [HW-1:0] fcnt_q;
  logic          phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fcnt_q  <= '0;
      phase_q <= 1'b0;
    end else if (frame_i) begin
      if (fcnt_q == HW'(HALF - 1)) begin
        fcnt_q  <= '0;
        phase_q <= ~phase_q;
      end else begin
        fcnt_q <= fcnt_q + 1'b1;
      end
    end
  end

  assign flash_o = phase_q;

  p_phase_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(flash_o));
endmodule

// File: rtl/dtg_selftest.sv
module dtg_selftest #(
  parameter int unsigned ST_CYC = 262144
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned SW = $clog2(ST_CYC + 1);

  logic [SW-1:0] rem_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      busy_q <= 1'b0;
    end else if (!busy_q) begin
      if (start_i) begin
        rem_q  <= SW'(ST_CYC);
        busy_q <= 1'b1;
      end
    end else if (tick_i) begin
      rem_q <= rem_q - 1'b1;
      if (rem_q == SW'(1)) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;

  p_busy_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  p_busy_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i) |=> (busy_o && $stable(rem_q)));
  p_restart_ign_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !tick_i) |=> $stable(rem_q));
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen #(
  parameter int unsigned ROW_CYC      = 32,
  parameter int unsigned ROWS         = 7,
  parameter int unsigned FLASH_FRAMES = 128,
  parameter int unsigned ST_CYC       = 262144
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clk_sel_i,
  input  logic                    osc_tick_i,
  input  logic                    pin_tick_i,
  output logic                    clk_pin_o,
  output logic                    clk_pin_oe_o,
  input  logic                    st_start_i,
  output logic [$clog2(ROWS)-1:0] row_o,
  output logic                    frame_o,
  output logic                    flash_o,
  output logic                    st_busy_o
);
  import dtg_pkg::*;

  tick_src_e src;
  logic      tick;

  // clock mux modelled as a tick-enable select
  assign src          = tick_src_e'(clk_sel_i);
  assign tick         = (src == SRC_OSC) ? osc_tick_i : pin_tick_i;
  assign clk_pin_oe_o = (src == SRC_OSC);
  assign clk_pin_o    = (src == SRC_OSC) & osc_tick_i;

  dtg_row_scan #(.ROW_CYC(ROW_CYC), .ROWS(ROWS)) i_row (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .row_o   (row_o),
    .frame_o (frame_o)
  );

  dtg_flash #(.FLASH_FRAMES(FLASH_FRAMES)) i_flash (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .frame_i (frame_o),
    .flash_o (flash_o)
  );

  dtg_selftest #(.ST_CYC(ST_CYC)) i_st (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .start_i (st_start_i),
    .busy_o  (st_busy_o)
  );

  p_pin_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_pin_oe_o |-> !clk_pin_o);
  p_pin_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_sel_i && !osc_tick_i) |=> $stable(row_o));
endmodule

// File: tb/test_disp_timing_gen.sv
module test_disp_timing_gen;
  localparam int unsigned ROW_CYC = 4;
  localparam int unsigned ROWS    = 7;
  localparam int unsigned FLF     = 4;
  localparam int unsigned ST_CYC  = 100;
  localparam int unsigned FRAME   = ROW_CYC * ROWS;
  localparam int unsigned PHASE   = FRAME * FLF / 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic clk_sel = 1'b1, osc_tick = 1'b0, pin_tick = 1'b0, st_start = 1'b0;
  logic clk_pin, clk_pin_oe, frame, flash, busy;
  logic [2:0] row;

  int n_chk = 0, n_fail = 0;
  int unsigned nt = 0;
  int unsigned rem = 0;
  bit exp_busy = 1'b0;

  always #2 clk = ~clk;

  disp_timing_gen #(.ROW_CYC(ROW_CYC), .ROWS(ROWS), .FLASH_FRAMES(FLF), .ST_CYC(ST_CYC))
  i_disp_timing_gen (
    .clk_i(clk), .rst_ni(rst_ni), .clk_sel_i(clk_sel), .osc_tick_i(osc_tick),
    .pin_tick_i(pin_tick), .clk_pin_o(clk_pin), .clk_pin_oe_o(clk_pin_oe),
    .st_start_i(st_start), .row_o(row), .frame_o(frame), .flash_o(flash),
    .st_busy_o(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // one system clock: drive, check combinational outputs, clock, check state
  task automatic step(input bit sel, input bit osc, input bit pin, input bit st);
    bit tk;
    @(negedge clk);
    clk_sel = sel; osc_tick = osc; pin_tick = pin; st_start = st;
    tk = sel ? osc : pin;
    #1;
    chk("R3 oe", int'(clk_pin_oe), int'(sel));
    chk("R3 pin", int'(clk_pin), int'(sel & osc));
    chk("R5 frame", int'(frame), int'(tk && (nt % FRAME == FRAME - 1)));
    @(posedge clk);
    if (tk) nt++;
    if (!exp_busy) begin
      if (st) begin exp_busy = 1'b1; rem = ST_CYC; end
    end else if (tk) begin
      rem--;
      if (rem == 0) exp_busy = 1'b0;
    end
    #1;
    chk("R4 R2 row", int'(row), int'((nt / ROW_CYC) % ROWS));
    chk("R6 flash", int'(flash), int'((nt / PHASE) % 2));
    chk("R7 R8 busy", int'(busy), int'(exp_busy));
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #5;
    // R1 reset state
    chk("R1 row", int'(row), 0);
    chk("R1 frame", int'(frame), 0);
    chk("R1 flash", int'(flash), 0);
    chk("R1 busy", int'(busy), 0);
    @(negedge clk); rst_ni = 1'b1;

    // R4 R5: dense internal ticks through several frames
    for (int i = 0; i < 3 * FRAME; i++) step(1'b1, 1'b1, 1'b0, 1'b0);
    // R2 R9: unselected tick only, no change expected
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 1'b0, 1'b0);
    // R2: pin source, dense
    for (int i = 0; i < 2 * FRAME; i++) step(1'b0, 1'b0, 1'b1, 1'b0);
    // R6 R9: sparse mixed pattern with source switching
    for (int i = 0; i < 900; i++) begin
      bit s = (i / 37) % 2 == 0;
      step(s, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'b0);
    end

    // R7: self-test start together with a tick, then sparse ticks
    step(1'b1, 1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 60; i++) step(1'b1, 1'(i % 2), 1'b0, 1'b0);
    // R8: restarts while busy are ignored
    for (int i = 0; i < 10; i++) step(1'b1, 1'(i % 3 == 0), 1'b0, 1'b1);
    for (int i = 0; i < 250 && exp_busy; i++) step(1'b0, 1'b0, 1'(i % 2), 1'b0);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R7 busy end", int'(busy), 0);

    // R7: second run with dense ticks, restart tried during it
    step(1'b1, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < ST_CYC + 5; i++) step(1'b1, 1'b1, 1'b0, 1'(i == 40));
    chk("R7 second run end", int'(busy), 0);

    finish_run();
  end
endmodule